// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block collects interrupt requests from four statically wired sources on a small embedded processor board: the interval timer (about every 10 ms), the network interface adapter and two serial ports. Each source sits on a fixed line number of an eight-line request space. A rising edge on a source that is not masked latches a request bit. The controller raises a single interrupt output to the CPU when a pending request outranks everything already in service. Priority is fixed and fully nested: a lower line number always wins.

The CPU takes an interrupt with a one-cycle acknowledge strobe. While the strobe is high, the block presents a vector equal to a software-written base plus the winning line number. On the clock edge that ends the strobe, the winning request moves from pending to in-service. Service ends only when software writes a specific end-of-interrupt command that names the line. Any other command is ignored.

Software reaches the block through a four-address register port. Address 0 reads the request register and accepts commands when written. Address 1 reads the in-service register. Address 2 holds the mask, where a set bit blocks the line. Address 3 holds the vector base.

Top module: `pic_fixed_nest`

## Requirements
- R1: After reset the request, in-service, mask and base registers read 0 and cpu_int is low.
- R2: Source bit 0 (interval timer) drives line 0, bit 1 (network adapter) drives line 5, bit 2 (first serial port) drives line 4 and bit 3 (second serial port) drives line 3. Register bits of the other lines always read 0, so writing 0xFF to the mask reads back 0x39.
- R3: A rising edge on an unmasked source sets its request bit at the clock edge that samples it, and cpu_int goes high after that same edge. A level that stays high sets the bit only once.
- R4: An edge on a masked source is not latched. Setting the mask bit of a line that is already pending removes that line from arbitration and from cpu_int, and the request bit stays set.
- R5: Among unmasked pending lines, the lowest line number is acknowledged first.
- R6: While ack is high, ack_vec equals base + line of the winner. At the clock edge where ack is high, the winner's request bit clears and its in-service bit sets.
- R7: cpu_int is high only while the highest-priority unmasked pending line has a lower number than the highest-priority in-service line, or while nothing is in service.
- R8: An ack while cpu_int is low returns base + 7 and changes no register.
- R9: Writing 0x60 | L to address 0 clears in-service bit L.
- R10: A specific EOI that names a line not in service, or any command whose bits 7..3 differ from 01100 (for example the non-specific 0x20), leaves every register unchanged.
- R11: If a new rising edge on a line arrives in the same cycle that an ack takes that line, the line ends up both in service and pending again.
- R12: The low three bits of the base register are forced to zero on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 4 | Source request levels: timer, network adapter, serial 1, serial 2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data or command |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ack | input | 1 | Interrupt acknowledge strobe, one cycle |
| ack_vec | output | 8 | Vector presented while ack is high |
| cpu_int | output | 1 | Interrupt request to the CPU |

## Verification
Two pairs of functions can meet in one cycle. The first pair is an acknowledge that takes a line and a fresh rising edge on that same line. The bench releases the timer after its first request, then raises it again in the very cycle it strobes ack. It then expects the line to be in service and pending at once. The second pair is nesting against end-of-interrupt. A higher-priority request is raised while a lower one is in service, and a lower-priority request is raised while a higher one is in service. The bench judges cpu_int before and after each specific EOI, and judges the vector order that follows.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      A_REQ_CMD = 2'd0,
      A_INSERV  = 2'd1,
      A_MASK    = 2'd2,
      A_BASE    = 2'd3
   } pic_addr_e;

   // upper field of a specific end-of-interrupt command (0x60 >> 3)
   localparam int EOI_SPEC_CODE = 12;
endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
   parameter int NLINES = 8,
   parameter logic [NLINES-1:0] SUP = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] lines,
   input  logic [NLINES-1:0] mask,
   input  logic [NLINES-1:0] clr,
   output logic [NLINES-1:0] req
);
   logic [NLINES-1:0] prev_q;
   logic [NLINES-1:0] rise;
   logic [NLINES-1:0] req_d;

   assign rise  = lines & ~prev_q;
   assign req_d = ((req & ~clr) | (rise & ~mask)) & SUP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         req    <= '0;
      end else begin
         prev_q <= lines;
         req    <= req_d;
      end
   end

   // a masked line that is not pending must not become pending
   p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((req & $past(mask & ~req)) == '0));
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
   parameter int NLINES = 8,
   localparam int LW = $clog2(NLINES)
) (
   input  logic [NLINES-1:0] pend,
   input  logic [NLINES-1:0] inserv,
   output logic              pend_valid,
   output logic [LW-1:0]     pend_idx,
   output logic              want_int
);
   logic          srv_valid;
   logic [LW-1:0] srv_idx;

   always_comb begin
      pend_valid = 1'b0;
      pend_idx   = '0;
      srv_valid  = 1'b0;
      srv_idx    = '0;
      for (int i = NLINES - 1; i >= 0; i--) begin
         if (pend[i]) begin
            pend_valid = 1'b1;
            pend_idx   = LW'(i);
         end
         if (inserv[i]) begin
            srv_valid = 1'b1;
            srv_idx   = LW'(i);
         end
      end
      want_int = pend_valid && (!srv_valid || (pend_idx < srv_idx));
   end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
   parameter int NLINES = 8,
   parameter logic [NLINES-1:0] SUP = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] take,
   input  logic [NLINES-1:0] retire,
   output logic [NLINES-1:0] inserv
);
   always_ff @(posedge clk) begin
      if (!rst_n) inserv <= '0;
      else        inserv <= ((inserv & ~retire) | take) & SUP;
   end

   p_sup_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take & ~SUP) == '0 |=> (inserv & ~SUP) == '0);

   p_take_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));
endmodule

// File: rtl/pic_regs.sv
module pic_regs
   import pic_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int VW = 8,
   parameter logic [NLINES-1:0] SUP = '1,
   localparam int LW = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [VW-1:0]     wdata,
   input  logic [NLINES-1:0] req,
   input  logic [NLINES-1:0] inserv,
   output logic [VW-1:0]     rdata,
   output logic [NLINES-1:0] mask,
   output logic [VW-1:0]     base
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '0;
         base <= '0;
      end else if (wr) begin
         if (addr == A_MASK) mask <= wdata[NLINES-1:0] & SUP;
         if (addr == A_BASE) base <= {wdata[VW-1:LW], {LW{1'b0}}};
      end
   end

   always_comb begin
      unique case (addr)
         A_REQ_CMD: rdata = VW'(req);
         A_INSERV:  rdata = VW'(inserv);
         A_MASK:    rdata = VW'(mask);
         default:   rdata = base;
      endcase
   end

   p_mask_rb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_MASK) |-> ((rdata[NLINES-1:0] & ~SUP) == '0));
endmodule

// File: rtl/pic_fixed_nest.sv
module pic_fixed_nest
   import pic_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int VW = 8,
   parameter int NSRC = 4,
   parameter int SRC_LINE [NSRC] = '{0, 5, 4, 3}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] irq_src,
   input  logic            reg_wr,
   input  logic [1:0]      reg_addr,
   input  logic [VW-1:0]   reg_wdata,
   output logic [VW-1:0]   reg_rdata,
   input  logic            ack,
   output logic [VW-1:0]   ack_vec,
   output logic            cpu_int
);
   localparam int LW = $clog2(NLINES);

   function automatic logic [NLINES-1:0] sup_of();
      logic [NLINES-1:0] m = '0;
      for (int s = 0; s < NSRC; s++) m[SRC_LINE[s]] = 1'b1;
      return m;
   endfunction
   localparam logic [NLINES-1:0] SUP = sup_of();

   generate
      if (NLINES != (1 << LW)) begin : g_bad_lines
         $error("NLINES must be a power of two");
      end
      if (VW <= LW) begin : g_bad_vw
         $error("VW must exceed the line index width");
      end
      for (genvar s = 0; s < NSRC; s++) begin : g_chk
         if (SRC_LINE[s] >= NLINES) begin : g_bad_map
            $error("source mapped outside line range");
         end
      end
   endgenerate

   logic [NLINES-1:0] lines, req, inserv, mask, pend, take, retire;
   logic [VW-1:0]     base;
   logic              pend_valid, want_int, eoi_spec;
   logic [LW-1:0]     pend_idx;

   always_comb begin
      lines = '0;
      for (int s = 0; s < NSRC; s++) lines[SRC_LINE[s]] = irq_src[s];
   end

   assign pend     = req & ~mask;
   assign eoi_spec = reg_wr && (reg_addr == A_REQ_CMD) &&
                     (reg_wdata[VW-1:LW] == (VW-LW)'(EOI_SPEC_CODE));
   assign retire   = eoi_spec ? (NLINES'(1) << reg_wdata[LW-1:0]) : '0;
   assign take     = (ack && want_int) ? (NLINES'(1) << pend_idx) : '0;
   assign ack_vec  = base | VW'(want_int ? pend_idx : {LW{1'b1}});
   assign cpu_int  = want_int;

   pic_edge_capture #(.NLINES(NLINES), .SUP(SUP)) u_edge (
      .clk(clk), .rst_n(rst_n), .lines(lines), .mask(mask),
      .clr(take), .req(req));

   pic_resolve #(.NLINES(NLINES)) u_res (
      .pend(pend), .inserv(inserv), .pend_valid(pend_valid),
      .pend_idx(pend_idx), .want_int(want_int));

   pic_service #(.NLINES(NLINES), .SUP(SUP)) u_srv (
      .clk(clk), .rst_n(rst_n), .take(take), .retire(retire),
      .inserv(inserv));

   pic_regs #(.NLINES(NLINES), .VW(VW), .SUP(SUP)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .req(req), .inserv(inserv), .rdata(reg_rdata),
      .mask(mask), .base(base));

   p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && cpu_int && !eoi_spec) |=>
         ($countones(inserv) == $past($countones(inserv)) + 1));

   p_spur_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !cpu_int) |-> (ack_vec[LW-1:0] == {LW{1'b1}}));

   p_bad_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_REQ_CMD && !eoi_spec && !ack) |=> $stable(inserv));

   p_int_has_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int |-> (req & ~mask) != '0);
endmodule

// File: tb/sim_pic_fixed_nest.sv
module sim_pic_fixed_nest;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] irq_src = '0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ack = 1'b0;
   logic [7:0] ack_vec;
   logic       cpu_int;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pic_fixed_nest u0 (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ack(ack), .ack_vec(ack_vec), .cpu_int(cpu_int));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_src = '0; reg_wr = 1'b0; ack = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse(input logic [3:0] m);
      irq_src = irq_src | m;
      tick();
      irq_src = irq_src & ~m;
      tick();
   endtask

   task automatic do_ack(output int v);
      ack = 1'b1;
      #1;
      v = ack_vec;
      tick();
      ack = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      rd(0, v); chk("R1 req", v, 0);
      rd(1, v); chk("R1 inserv", v, 0);
      rd(2, v); chk("R1 mask", v, 0);
      rd(3, v); chk("R1 base", v, 0);
      chk("R1 cpu_int", cpu_int, 0);
   endtask

   task automatic t_order();
      int v;
      do_reset();
      wr(2, 8'hFF);
      rd(2, v); chk("R2 mask readback", v, 8'h39);
      wr(2, 8'h00);
      pulse(4'hF);
      rd(0, v); chk("R2 line map", v, 8'h39);
      do_ack(v); chk("R5 first vector", v, 0);
      rd(1, v); chk("R6 inserv after ack", v, 8'h01);
      rd(0, v); chk("R6 req cleared", v, 8'h38);
      chk("R7 lower pending blocked", cpu_int, 0);
      wr(0, 8'h60);
      chk("R9 eoi reopens", cpu_int, 1);
      do_ack(v); chk("R5 second vector", v, 3);
      wr(0, 8'h63);
      do_ack(v); chk("R5 third vector", v, 4);
      wr(0, 8'h64);
      do_ack(v); chk("R5 fourth vector", v, 5);
      wr(0, 8'h65);
      rd(1, v); chk("R9 all retired", v, 0);
   endtask

   task automatic t_level();
      int v;
      do_reset();
      irq_src[0] = 1'b1;
      tick();
      chk("R3 cpu_int after edge", cpu_int, 1);
      do_ack(v);
      wr(0, 8'h60);
      tick(); tick();
      rd(0, v); chk("R3 held level once", v, 0);
      chk("R3 no reassert", cpu_int, 0);
      irq_src = '0;
      tick();
   endtask

   task automatic t_mask();
      int v;
      do_reset();
      wr(2, 8'h01);
      pulse(4'b0001);
      rd(0, v); chk("R4 masked edge dropped", v, 0);
      chk("R4 no int", cpu_int, 0);
      pulse(4'b0010);
      chk("R4 unmasked int", cpu_int, 1);
      wr(2, 8'h21);
      chk("R4 pending masked out", cpu_int, 0);
      rd(0, v); chk("R4 pending kept", v, 8'h20);
      do_ack(v); chk("R8 masked ack spurious", v, 7);
   endtask

   task automatic t_nest();
      int v;
      do_reset();
      pulse(4'b0010);
      do_ack(v); chk("R6 net vector", v, 5);
      pulse(4'b0001);
      chk("R7 higher interrupts", cpu_int, 1);
      do_ack(v); chk("R7 nested vector", v, 0);
      rd(1, v); chk("R7 nested inserv", v, 8'h21);
      pulse(4'b1000);
      chk("R7 line3 blocked by 0", cpu_int, 0);
      wr(0, 8'h60);
      chk("R7 line3 beats 5", cpu_int, 1);
   endtask

   task automatic t_spur();
      int v;
      do_reset();
      wr(3, 8'h40);
      do_ack(v); chk("R8 spurious vector", v, 8'h47);
      rd(1, v); chk("R8 inserv unchanged", v, 0);
      rd(0, v); chk("R8 req unchanged", v, 0);
   endtask

   task automatic t_eoi();
      int v;
      do_reset();
      pulse(4'b0100);
      do_ack(v);
      pulse(4'b1000);
      wr(0, 8'h63);
      rd(1, v); chk("R10 eoi other line", v, 8'h10);
      rd(0, v); chk("R10 req intact", v, 8'h08);
      wr(0, 8'h20);
      rd(1, v); chk("R10 non-specific ignored", v, 8'h10);
      wr(0, 8'h64);
      rd(1, v); chk("R9 specific eoi", v, 0);
   endtask

   task automatic t_same();
      int v;
      do_reset();
      pulse(4'b0001);
      irq_src[0] = 1'b1;
      do_ack(v); chk("R11 vector", v, 0);
      rd(1, v); chk("R11 inserv", v, 8'h01);
      rd(0, v); chk("R11 req again", v, 8'h01);
      irq_src = '0;
      tick();
   endtask

   task automatic t_base();
      int v;
      do_reset();
      wr(3, 8'hA5);
      rd(3, v); chk("R12 base low bits", v, 8'hA0);
      pulse(4'b0100);
      do_ack(v); chk("R12 vector", v, 8'hA4);
   endtask

   initial begin
      t_reset();
      t_order();
      t_level();
      t_mask();
      t_nest();
      t_spur();
      t_eoi();
      t_same();
      t_base();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule